// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Gate

This block controls a group of differential clock outputs. Each output has a true phase and a complement phase. A fast internal reference clock drives a phase generator, and the generator makes one running clock phase that all outputs share. Each output lane either follows that phase, parks while a stop request is in force, or shows a fixed level when its register enable is cleared.

The stop request arrives asynchronously and is active low. A lane marked stoppable enters its parked state (true high, complement low) only at the point where the running phase goes high. It leaves that state only at the point where the phase goes low. Because of this, no lane ever produces a runt or stretched low pulse. Lanes not marked stoppable ignore the request. A short glitch on the request line is filtered out before it reaches any lane. The register bank that feeds the stoppable mask and the enables is expected to reset them to all-free-running and all-enabled.

Top module: `diff_clk_stop_gate`

## Requirements
- R1: While reset is asserted, every true output is 0 and every complement output is 1.
- R2: The stop request is active low. It takes effect only after two consecutive synchronized samples agree, and a release needs the same. A low pulse lasting one reference cycle has no effect on any output.
- R3: Once a request is accepted, every enabled lane whose stoppable bit is 1 parks within one output period. A parked lane shows true = 1 and complement = 0 and holds that level while the request stays asserted.
- R4: A lane enters the parked state only on a low-to-high transition of its true output. No high pulse is ever shorter than HALF_CYCLES reference cycles.
- R5: A lane whose stoppable bit is 0 keeps toggling while the request is asserted.
- R6: Once a release is accepted, a parked lane resumes within one output period, starting with a high-to-low transition. Every low pulse of an enabled lane lasts exactly HALF_CYCLES reference cycles.
- R7: When a lane's enable is 0, its outputs are fixed one cycle later. With park_low_i = 1 both phases are 0. With park_low_i = 0 the true phase is 1 and the complement is 0. Other lanes are not affected.
- R8: For an enabled lane, the complement output is always the inverse of the true output.
- R9: A running lane has a period of 2*HALF_CYCLES reference cycles with equal high and low times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_req_ni | input | 1 | Asynchronous stop request, active low |
| stoppable_i | input | NUM_OUT | Per-lane stoppable mask (1 = obeys the stop request) |
| enable_i | input | NUM_OUT | Per-lane register enable (1 = lane driven) |
| park_low_i | input | 1 | Level chosen for disabled lanes: 1 = both phases low, 0 = true high |
| clk_t_o | output | NUM_OUT | True phase of each lane |
| clk_c_o | output | NUM_OUT | Complement phase of each lane |

## Verification
The bench sends a single-cycle request glitch. A gate without the two-sample filter would park its stoppable lanes, and the bench would see extra high time. It stops a mixed mask and checks two things: that the masked lanes hold high and that the unmasked lane keeps its exact duty. A design that parked at the wrong phase would instead show a clipped high pulse or a runt low pulse to the pulse-width monitor. The bench measures restart latency against the one-period bound. It also exercises both park levels for a disabled lane, where a swapped mode decode shows up directly at the pins.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
   typedef enum logic {
      PARK_TRUE_HIGH = 1'b0,
      PARK_BOTH_LOW  = 1'b1
   } park_mode_e;

   function automatic int cnt_width(input int half_cycles);
      return (half_cycles > 1) ? $clog2(half_cycles) : 1;
   endfunction
endpackage

// File: rtl/cstop_phase_gen.sv
module cstop_phase_gen #(
   parameter int HALF_CYCLES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic phase_o,
   output logic rise_next_o,
   output logic fall_next_o
);
   localparam int CW = clkstop_pkg::cnt_width(HALF_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap        = (cnt_q == LAST);
   assign rise_next_o = wrap & ~phase_o;
   assign fall_next_o = wrap &  phase_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         phase_o <= 1'b0;
      end else if (wrap) begin
         cnt_q   <= '0;
         phase_o <= ~phase_o;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R9: the phase only flips after a full half period has been counted
   assert_half_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o != $past(phase_o)) |-> ($past(cnt_q) == LAST));

   assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);
endmodule

// File: rtl/cstop_req_filter.sv
module cstop_req_filter (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_ni,
   output logic stop_o
);
   logic       meta_q;
   logic [1:0] hist_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         meta_q <= 1'b1;
         hist_q <= 2'b11;
         stop_o <= 1'b0;
      end else begin
         meta_q <= req_ni;
         hist_q <= {hist_q[0], meta_q};
         if (hist_q == 2'b00)      stop_o <= 1'b1;
         else if (hist_q == 2'b11) stop_o <= 1'b0;
      end
   end

   // R2: acceptance needs the pin low on two consecutive sampling edges
   assert_accept_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stop_o) |-> (!$past(req_ni, 3) && !$past(req_ni, 4)));

   assert_release_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(stop_o) |-> ($past(req_ni, 3) && $past(req_ni, 4)));
endmodule

// File: rtl/cstop_lane.sv
module cstop_lane (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic phase_i,
   input  logic rise_next_i,
   input  logic fall_next_i,
   input  logic stop_i,
   input  logic stoppable_i,
   input  logic enable_i,
   input  logic park_low_i,
   output logic out_t_o,
   output logic out_c_o
);
   import clkstop_pkg::*;

   park_mode_e park_mode;
   logic       stopped_q, stopped_d, phase_d, run_d;

   assign park_mode = park_mode_e'(park_low_i);

   always_comb begin
      stopped_d = stopped_q;
      if (rise_next_i && stop_i && stoppable_i) stopped_d = 1'b1;
      else if (fall_next_i && !stop_i)          stopped_d = 1'b0;
      phase_d = rise_next_i ? 1'b1 : (fall_next_i ? 1'b0 : phase_i);
      run_d   = stopped_d | phase_d;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stopped_q <= 1'b0;
         out_t_o   <= 1'b0;
         out_c_o   <= 1'b1;
      end else begin
         stopped_q <= stopped_d;
         if (enable_i) begin
            out_t_o <= run_d;
            out_c_o <= ~run_d;
         end else begin
            out_t_o <= (park_mode == PARK_TRUE_HIGH);
            out_c_o <= 1'b0;
         end
      end
   end

   assert_park_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(enable_i) && stopped_q) |-> (out_t_o && !out_c_o));

   assert_enter_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(stopped_q) && $past(enable_i) && $past(enable_i, 2))
      |-> (out_t_o && !$past(out_t_o)));

   assert_free_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!stoppable_i) && !$past(stopped_q)) |-> !stopped_q);

   assert_exit_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(stopped_q) && $past(enable_i) && $past(enable_i, 2))
      |-> (!out_t_o && $past(out_t_o)));

   assert_disabled_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(enable_i) |-> ((out_t_o == !$past(park_low_i)) && !out_c_o));

   assert_complement_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(enable_i) |-> (out_c_o == !out_t_o));
endmodule

// File: rtl/diff_clk_stop_gate.sv
module diff_clk_stop_gate #(
   parameter int NUM_OUT     = 3,
   parameter int HALF_CYCLES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               stop_req_ni,
   input  logic [NUM_OUT-1:0] stoppable_i,
   input  logic [NUM_OUT-1:0] enable_i,
   input  logic               park_low_i,
   output logic [NUM_OUT-1:0] clk_t_o,
   output logic [NUM_OUT-1:0] clk_c_o
);
   if (NUM_OUT < 1) begin : g_bad_num
      $error("NUM_OUT must be at least 1");
   end
   if (HALF_CYCLES < 1) begin : g_bad_half
      $error("HALF_CYCLES must be at least 1");
   end

   logic phase, rise_next, fall_next, stop_act;

   cstop_phase_gen #(.HALF_CYCLES(HALF_CYCLES)) u_phase (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .phase_o     (phase),
      .rise_next_o (rise_next),
      .fall_next_o (fall_next)
   );

   cstop_req_filter u_filter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_ni (stop_req_ni),
      .stop_o (stop_act)
   );

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
      cstop_lane u_lane (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .phase_i     (phase),
         .rise_next_i (rise_next),
         .fall_next_i (fall_next),
         .stop_i      (stop_act),
         .stoppable_i (stoppable_i[g]),
         .enable_i    (enable_i[g]),
         .park_low_i  (park_low_i),
         .out_t_o     (clk_t_o[g]),
         .out_c_o     (clk_c_o[g])
      );
   end
endmodule

// File: tb/diff_clk_stop_gate_tb.sv
module diff_clk_stop_gate_tb;
   localparam int N    = 3;
   localparam int HALF = 2;
   localparam int PER  = 2 * HALF;
   localparam int WD_LIMIT = 100000;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         stop_n;
   logic [N-1:0] mask, en;
   logic         park_low;
   logic [N-1:0] t, c;

   int checks = 0;
   int failures = 0;
   int cyc_cnt = 0;
   bit mon_on = 1'b0;
   int hc[N];
   int cc[N];
   int cerr;

   always #2 clk = ~clk;

   diff_clk_stop_gate #(.NUM_OUT(N), .HALF_CYCLES(HALF)) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .stop_req_ni (stop_n),
      .stoppable_i (mask),
      .enable_i    (en),
      .park_low_i  (park_low),
      .clk_t_o     (t),
      .clk_c_o     (c)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sample_run(input int n);
      for (int i = 0; i < N; i++) begin hc[i] = 0; cc[i] = 0; end
      cerr = 0;
      repeat (n) begin
         @(negedge clk);
         for (int i = 0; i < N; i++) begin
            if (t[i]) hc[i]++;
            if (c[i]) cc[i]++;
            if (en[i] && (c[i] == t[i])) cerr++;
         end
      end
   endtask

   // pulse-width monitor: low runs exactly HALF (R6), high runs at least HALF (R4)
   int  run_len[N];
   bit  seen[N];
   logic prev[N];
   always @(negedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!mon_on || !en[i] || !rst_n) begin
            seen[i] = 1'b0; run_len[i] = 0; prev[i] = t[i];
         end else if (t[i] == prev[i]) begin
            run_len[i]++;
         end else begin
            if (seen[i]) begin
               if (prev[i] == 1'b0) check(run_len[i] == HALF, "R6 low pulse width", run_len[i], HALF);
               else                 check(run_len[i] >= HALF, "R4 high pulse width", run_len[i], HALF);
            end
            seen[i] = 1'b1; run_len[i] = 1; prev[i] = t[i];
         end
      end
   end

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt == WD_LIMIT) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc_cnt, WD_LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic t_reset();
      rst_n = 1'b0; stop_n = 1'b1; mask = '0; en = '1; park_low = 1'b0;
      cyc(4);
      check(t == '0, "R1 true outputs in reset", t, 0);
      check(c == '1, "R1 complement outputs in reset", c, 7);
      rst_n = 1'b1;
      mon_on = 1'b1;
      cyc(2);
   endtask

   task automatic t_free_run();
      sample_run(4 * PER);
      for (int i = 0; i < N; i++)
         check(hc[i] == 2 * PER, "R9 duty over four periods", hc[i], 2 * PER);
      check(cerr == 0, "R8 complement mismatches", cerr, 0);
   endtask

   task automatic t_short_pulse();
      mask = '1;
      stop_n = 1'b0;
      cyc(1);
      stop_n = 1'b1;
      sample_run(4 * PER);
      for (int i = 0; i < N; i++)
         check(hc[i] == 2 * PER, "R2 glitch ignored", hc[i], 2 * PER);
   endtask

   task automatic t_stop_resume();
      int lat;
      mask = 3'b101;
      stop_n = 1'b0;
      cyc(3 + 2 * PER + 2);
      sample_run(2 * PER);
      check(hc[0] == 2 * PER, "R3 lane0 parked high", hc[0], 2 * PER);
      check(hc[2] == 2 * PER, "R3 lane2 parked high", hc[2], 2 * PER);
      check(cc[0] == 0 && cc[2] == 0, "R3 parked complement low", cc[0] + cc[2], 0);
      check(hc[1] == PER, "R5 unmasked lane runs", hc[1], PER);
      stop_n = 1'b1;
      lat = 0;
      while (t[0] && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      check(lat <= 3 + 2 * PER + 1, "R6 restart latency", lat, 3 + 2 * PER + 1);
      cyc(1);
      sample_run(4 * PER);
      for (int i = 0; i < N; i++)
         check(hc[i] == 2 * PER, "R6 running after release", hc[i], 2 * PER);
      mask = '0;
   endtask

   task automatic t_disable();
      park_low = 1'b1;
      en = 3'b101;
      cyc(2);
      sample_run(PER);
      check(hc[1] == 0 && cc[1] == 0, "R7 mode1 both low", hc[1] + cc[1], 0);
      check(hc[0] == HALF, "R7 neighbour unaffected", hc[0], HALF);
      park_low = 1'b0;
      cyc(2);
      sample_run(PER);
      check(hc[1] == PER && cc[1] == 0, "R7 mode0 true high", hc[1] * 10 + cc[1], PER * 10);
      en = '1;
      cyc(4);
      sample_run(4 * PER);
      check(hc[1] == 2 * PER, "R7 lane resumes on enable", hc[1], 2 * PER);
      check(cerr == 0, "R8 complement after enable", cerr, 0);
   endtask

   initial begin
      t_reset();
      t_free_run();
      t_short_pulse();
      t_stop_resume();
      t_disable();
      mon_on = 1'b0;
      cyc(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule